// File: doc/BRIEF.md
# Hamming Single-Error-Correcting Codec

This block protects a 16-bit memory word with five even-parity check bits, giving a 21-bit codeword that can recover from any one flipped bit. It has two independent paths that share a clock. The encode path takes a data word and returns its codeword. The decode path takes a codeword that may be damaged, recomputes every check, and returns the repaired data word together with the syndrome and two status flags.

Codeword positions are numbered 1 to 21, and position 1 is the most significant bit of the 21-bit vector. Every position whose number is a power of two holds a check bit. The data bits fill the other positions, with the most significant data bit at the lowest-numbered free position. When the decoder sees a damaged word, the syndrome is the sum of the numbers of the failing checks, and that sum names the damaged position directly. Each path registers its result and has one cycle of latency. A valid strobe qualifies the input of each path and the output of each path.

Top module: `hsec_top`

## Requirements
- R1: The codeword is 21 bits wide. Position p is carried on bit 21-p of the codeword ports. Check bits sit at positions 1, 2, 4, 8 and 16. For example, data 0x0001 encodes to 0x120021.
- R2: Data bits 15 down to 0 occupy positions 3, 5, 6, 7, 9–15 and 17–21, in ascending position order. For example, data 0x8000 encodes to 0x1C0000.
- R3: Each check bit at position c gives even parity over all positions whose number has bit c set. Data 0xF0AE encodes to 21'b001011100000101101110.
- R4: `enc_valid_o` equals `enc_valid_i` from the previous clock, and `enc_code_o` shows the codeword of the data presented with that valid. `enc_code_o` holds its value while no valid input arrives.
- R5: `dec_syndrome_o` is the sum of the position numbers of the failing checks, where bit k of the syndrome has weight 2^k. Flipping position 5 of the R3 codeword gives syndrome 5.
- R6: A zero syndrome clears both flags, and the data is passed through unchanged.
- R7: A syndrome that names a data position inverts that bit, sets `dec_corrected_o`, and outputs the original data word.
- R8: A syndrome that names a check-bit position sets `dec_corrected_o` and leaves the data bits unchanged.
- R9: A syndrome from 22 to 31 sets `dec_uncorr_o` and clears `dec_corrected_o`. The data bits are taken from the received word without correction.
- R10: `dec_valid_o` equals `dec_valid_i` from the previous clock. The data, syndrome and flag outputs hold their values while no valid input arrives.
- R11: While reset is active and after it is released, both valid outputs and all data outputs are zero until the first valid input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_valid_i | input | 1 | Encode request strobe |
| enc_data_i | input | 16 | Data word to encode |
| enc_valid_o | output | 1 | Encode result strobe |
| enc_code_o | output | 21 | Codeword, position 1 at bit 20 |
| dec_valid_i | input | 1 | Decode request strobe |
| dec_code_i | input | 21 | Received codeword, position 1 at bit 20 |
| dec_valid_o | output | 1 | Decode result strobe |
| dec_data_o | output | 16 | Repaired data word |
| dec_syndrome_o | output | 5 | Position number named by the failing checks |
| dec_corrected_o | output | 1 | Syndrome named a position from 1 to 21 |
| dec_uncorr_o | output | 1 | Syndrome named no real position |

## Verification
The encoder is driven with fixed words whose codewords are known: a single data bit at each end of the word, all zeros, and the mixed pattern from R3. These words separate errors in data placement from errors in parity coverage. They are followed by random words.

The decoder receives four kinds of codeword:
- Clean codewords, which should give a zero syndrome.
- Codewords with each of the 21 positions flipped in turn. These separate repair of data positions from repair of check positions.
- Codewords with two chosen positions flipped, so that the syndrome exceeds 21. These exercise the uncorrectable path.
- Random codewords with two flips. These catch sums that land back in range.

Idle cycles with changing inputs confirm that the outputs hold.

// File: rtl/hsec_pkg.sv
package hsec_pkg;

    localparam int DEF_DATA_W = 16;

    function automatic logic is_pow2(input int v);
        return (v > 0) && ((v & (v - 1)) == 0);
    endfunction

    // smallest r with m + r + 1 <= 2**r
    function automatic int chk_bits(input int m);
        int r;
        r = 1;
        while ((m + r + 1) > (1 << r)) r++;
        return r;
    endfunction

endpackage

// File: rtl/hsec_enc.sv
module hsec_enc #(
    parameter int DATA_W = 16,
    parameter int CHK_W  = 5
) (
    input  logic [DATA_W-1:0]        data_i,
    output logic [DATA_W+CHK_W-1:0]  code_o
);
    localparam int CODE_W = DATA_W + CHK_W;

    always_comb begin
        logic [CODE_W-1:0] cw;
        logic par;
        int di;
        cw = '0;
        di = DATA_W - 1;
        for (int p = 1; p <= CODE_W; p++) begin
            if (!hsec_pkg::is_pow2(p) && di >= 0) begin
                cw[CODE_W-p] = data_i[di];
                di = di - 1;
            end
        end
        for (int k = 0; k < CHK_W; k++) begin
            par = 1'b0;
            for (int p = 1; p <= CODE_W; p++) begin
                if (((p >> k) & 1) == 1) par = par ^ cw[CODE_W-p];
            end
            cw[CODE_W-(1 << k)] = par;
        end
        code_o = cw;
    end
endmodule

// File: rtl/hsec_syn.sv
module hsec_syn #(
    parameter int CODE_W = 21,
    parameter int CHK_W  = 5
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [CHK_W-1:0]  syn_o
);
    always_comb begin
        syn_o = '0;
        for (int k = 0; k < CHK_W; k++) begin
            for (int p = 1; p <= CODE_W; p++) begin
                if (((p >> k) & 1) == 1) syn_o[k] = syn_o[k] ^ code_i[CODE_W-p];
            end
        end
    end
endmodule

// File: rtl/hsec_fix.sv
module hsec_fix #(
    parameter int DATA_W = 16,
    parameter int CHK_W  = 5
) (
    input  logic [DATA_W+CHK_W-1:0] code_i,
    input  logic [CHK_W-1:0]        syn_i,
    output logic [DATA_W-1:0]       data_o,
    output logic                    corr_o,
    output logic                    unc_o
);
    localparam int CODE_W = DATA_W + CHK_W;

    always_comb begin
        logic [CODE_W-1:0] fixed;
        int di;
        int s;
        s      = int'(syn_i);
        corr_o = (s != 0) && (s <= CODE_W);
        unc_o  = (s > CODE_W);
        fixed  = code_i;
        for (int p = 1; p <= CODE_W; p++) begin
            if (corr_o && (s == p)) fixed[CODE_W-p] = ~code_i[CODE_W-p];
        end
        data_o = '0;
        di = DATA_W - 1;
        for (int p = 1; p <= CODE_W; p++) begin
            if (!hsec_pkg::is_pow2(p) && di >= 0) begin
                data_o[di] = fixed[CODE_W-p];
                di = di - 1;
            end
        end
    end
endmodule

// File: rtl/hsec_top.sv
module hsec_top #(
    parameter int DATA_W = hsec_pkg::DEF_DATA_W,
    parameter int CHK_W  = hsec_pkg::chk_bits(DATA_W),
    parameter int CODE_W = DATA_W + CHK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enc_valid_i,
    input  logic [DATA_W-1:0] enc_data_i,
    output logic              enc_valid_o,
    output logic [CODE_W-1:0] enc_code_o,
    input  logic              dec_valid_i,
    input  logic [CODE_W-1:0] dec_code_i,
    output logic              dec_valid_o,
    output logic [DATA_W-1:0] dec_data_o,
    output logic [CHK_W-1:0]  dec_syndrome_o,
    output logic              dec_corrected_o,
    output logic              dec_uncorr_o
);
    typedef struct packed {
        logic              enc_v;
        logic [CODE_W-1:0] enc_code;
        logic              dec_v;
        logic [DATA_W-1:0] dec_data;
        logic [CHK_W-1:0]  syn;
        logic              corr;
        logic              unc;
    } state_t;

    state_t st_d, st_q;

    logic [CODE_W-1:0] enc_code_c;
    logic [CHK_W-1:0]  syn_c;
    logic [DATA_W-1:0] fix_data_c;
    logic              corr_c, unc_c;

    hsec_enc #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_enc (
        .data_i (enc_data_i),
        .code_o (enc_code_c)
    );

    hsec_syn #(.CODE_W(CODE_W), .CHK_W(CHK_W)) u_syn (
        .code_i (dec_code_i),
        .syn_o  (syn_c)
    );

    hsec_fix #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_fix (
        .code_i (dec_code_i),
        .syn_i  (syn_c),
        .data_o (fix_data_c),
        .corr_o (corr_c),
        .unc_o  (unc_c)
    );

    always_comb begin
        st_d       = st_q;
        st_d.enc_v = enc_valid_i;
        st_d.dec_v = dec_valid_i;
        if (enc_valid_i) st_d.enc_code = enc_code_c;
        if (dec_valid_i) begin
            st_d.dec_data = fix_data_c;
            st_d.syn      = syn_c;
            st_d.corr     = corr_c;
            st_d.unc      = unc_c;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign enc_valid_o     = st_q.enc_v;
    assign enc_code_o      = st_q.enc_code;
    assign dec_valid_o     = st_q.dec_v;
    assign dec_data_o      = st_q.dec_data;
    assign dec_syndrome_o  = st_q.syn;
    assign dec_corrected_o = st_q.corr;
    assign dec_uncorr_o    = st_q.unc;
endmodule

// File: rtl/hsec_chk.sv
module hsec_chk #(
    parameter int DATA_W = 16,
    parameter int CHK_W  = 5,
    parameter int CODE_W = 21
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enc_valid_i,
    input logic              enc_valid_o,
    input logic [CODE_W-1:0] enc_code_o,
    input logic              dec_valid_i,
    input logic              dec_valid_o,
    input logic [DATA_W-1:0] dec_data_o,
    input logic [CHK_W-1:0]  dec_syndrome_o,
    input logic              dec_corrected_o,
    input logic              dec_uncorr_o
);
    assert_enc_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (enc_valid_o == $past(enc_valid_i)));

    assert_enc_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !enc_valid_i |=> $stable(enc_code_o));

    assert_dec_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (dec_valid_o == $past(dec_valid_i)));

    assert_dec_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid_i |=> ($stable(dec_data_o) && $stable(dec_syndrome_o)));

    assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(dec_corrected_o && dec_uncorr_o));

    assert_zero_syn_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_syndrome_o == '0) |-> (!dec_corrected_o && !dec_uncorr_o));

    assert_out_of_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(dec_syndrome_o) > CODE_W) |-> dec_uncorr_o);

    assert_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((dec_syndrome_o != '0) && (int'(dec_syndrome_o) <= CODE_W)) |-> dec_corrected_o);
endmodule

bind hsec_top hsec_chk #(.DATA_W(DATA_W), .CHK_W(CHK_W), .CODE_W(CODE_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .enc_valid_i     (enc_valid_i),
    .enc_valid_o     (enc_valid_o),
    .enc_code_o      (enc_code_o),
    .dec_valid_i     (dec_valid_i),
    .dec_valid_o     (dec_valid_o),
    .dec_data_o      (dec_data_o),
    .dec_syndrome_o  (dec_syndrome_o),
    .dec_corrected_o (dec_corrected_o),
    .dec_uncorr_o    (dec_uncorr_o)
);

// File: tb/tb_hsec_top.sv
module tb_hsec_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enc_valid_i = 1'b0;
    logic [15:0] enc_data_i = '0;
    logic        enc_valid_o;
    logic [20:0] enc_code_o;
    logic        dec_valid_i = 1'b0;
    logic [20:0] dec_code_i = '0;
    logic        dec_valid_o;
    logic [15:0] dec_data_o;
    logic [4:0]  dec_syndrome_o;
    logic        dec_corrected_o, dec_uncorr_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference state
    logic        m_ev = 0, m_dv = 0, m_corr = 0, m_unc = 0;
    logic [20:0] m_code = '0;
    logic [15:0] m_data = '0;
    logic [4:0]  m_syn = '0;

    always #2 clk = ~clk;

    hsec_top dut (
        .clk(clk), .rst_n(rst_n),
        .enc_valid_i(enc_valid_i), .enc_data_i(enc_data_i),
        .enc_valid_o(enc_valid_o), .enc_code_o(enc_code_o),
        .dec_valid_i(dec_valid_i), .dec_code_i(dec_code_i),
        .dec_valid_o(dec_valid_o), .dec_data_o(dec_data_o),
        .dec_syndrome_o(dec_syndrome_o), .dec_corrected_o(dec_corrected_o),
        .dec_uncorr_o(dec_uncorr_o)
    );

    function automatic logic [20:0] ref_enc(input logic [15:0] d);
        bit pos [1:21];
        int k;
        k = 15;
        for (int p = 1; p <= 21; p++) begin
            pos[p] = 0;
            if (p != 1 && p != 2 && p != 4 && p != 8 && p != 16) begin
                pos[p] = d[k];
                k--;
            end
        end
        for (int c = 1; c <= 16; c = c * 2) begin
            bit x;
            x = 0;
            for (int p = 1; p <= 21; p++) if ((p & c) != 0 && p != c) x ^= pos[p];
            pos[c] = x;
        end
        ref_enc = '0;
        for (int p = 1; p <= 21; p++) ref_enc[21-p] = pos[p];
    endfunction

    function automatic logic [15:0] ref_extract(input logic [20:0] cw);
        int k;
        k = 15;
        ref_extract = '0;
        for (int p = 1; p <= 21; p++)
            if (p != 1 && p != 2 && p != 4 && p != 8 && p != 16) begin
                ref_extract[k] = cw[21-p];
                k--;
            end
    endfunction

    task automatic ref_dec(input logic [20:0] cw);
        int s;
        logic [20:0] f;
        s = 0;
        for (int p = 1; p <= 21; p++) if (cw[21-p]) s = s ^ p;
        m_syn  = 5'(s);
        m_corr = (s != 0) && (s <= 21);
        m_unc  = (s > 21);
        f = cw;
        if (m_corr) f[21-s] = ~f[21-s];
        m_data = ref_extract(f);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        chk({tag, " R4 enc_valid"}, 32'(enc_valid_o), 32'(m_ev));
        chk({tag, " R3 enc_code"}, 32'(enc_code_o), 32'(m_code));
        chk({tag, " R10 dec_valid"}, 32'(dec_valid_o), 32'(m_dv));
        chk({tag, " R7 dec_data"}, 32'(dec_data_o), 32'(m_data));
        chk({tag, " R5 syndrome"}, 32'(dec_syndrome_o), 32'(m_syn));
        chk({tag, " R8 corrected"}, 32'(dec_corrected_o), 32'(m_corr));
        chk({tag, " R9 uncorr"}, 32'(dec_uncorr_o), 32'(m_unc));
    endtask

    task automatic step(input string tag, input logic ev, input logic [15:0] ed,
                        input logic dv, input logic [20:0] dc);
        @(negedge clk);
        enc_valid_i = ev; enc_data_i = ed;
        dec_valid_i = dv; dec_code_i = dc;
        @(posedge clk);
        m_ev = ev; m_dv = dv;
        if (ev) m_code = ref_enc(ed);
        if (dv) ref_dec(dc);
        #1;
        compare_all(tag);
    endtask

    localparam logic [15:0] EX_D = 16'b1111000010101110;
    localparam logic [20:0] EX_C = 21'b001011100000101101110;

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [20:0] c;
        repeat (3) @(posedge clk);
        #1;
        // R11 reset state
        compare_all("R11 in reset");
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        compare_all("R11 after reset");

        // R3 example, R2/R1 single-bit placement
        step("R3 example", 1, EX_D, 1, EX_C);
        chk("R3 literal codeword", 32'(enc_code_o), 32'(EX_C));
        chk("R6 clean decode data", 32'(dec_data_o), 32'(EX_D));
        chk("R6 clean flags", 32'({dec_corrected_o, dec_uncorr_o}), 32'(0));
        step("R2 msb data", 1, 16'h8000, 0, '0);
        chk("R2 literal codeword", 32'(enc_code_o), 32'h1C0000);
        step("R1 lsb data", 1, 16'h0001, 0, '0);
        chk("R1 literal codeword", 32'(enc_code_o), 32'h120021);
        step("R1 zero data", 1, 16'h0000, 0, '0);

        // R5 position 5 flip
        step("R5 flip pos5", 0, 16'h1234, 1, EX_C ^ (21'd1 << 16));
        chk("R5 syndrome 5", 32'(dec_syndrome_o), 32'd5);
        chk("R7 repaired data", 32'(dec_data_o), 32'(EX_D));

        // R10/R4 hold under idle with changing inputs
        step("R10 hold", 0, 16'hFFFF, 0, 21'h1FFFFF);
        chk("R10 held syndrome", 32'(dec_syndrome_o), 32'd5);
        chk("R4 held code", 32'(enc_code_o), 32'h0);

        // R7/R8 every single position
        for (int p = 1; p <= 21; p++) begin
            step("R7 R8 single flip", 0, '0, 1, EX_C ^ (21'd1 << (21 - p)));
            chk("R8 flag on single flip", 32'(dec_corrected_o), 32'd1);
            chk("R7 data on single flip", 32'(dec_data_o), 32'(EX_D));
        end

        // R9 syndrome 23: flip positions 21 and 2
        c = EX_C ^ (21'd1 << 0) ^ (21'd1 << 19);
        step("R9 double flip", 0, '0, 1, c);
        chk("R9 uncorr set", 32'(dec_uncorr_o), 32'd1);
        chk("R9 syndrome 23", 32'(dec_syndrome_o), 32'd23);
        chk("R9 raw data", 32'(dec_data_o), 32'(ref_extract(c)));

        // random traffic with 0, 1 or 2 flips
        for (int i = 0; i < 400; i++) begin
            logic [15:0] d;
            int a, b, n;
            d = 16'($urandom);
            c = ref_enc(d);
            n = int'($urandom % 3);
            a = 1 + int'($urandom % 21);
            b = 1 + int'($urandom % 21);
            if (n >= 1) c[21-a] = ~c[21-a];
            if (n == 2 && b != a) c[21-b] = ~c[21-b];
            step("random", 1'($urandom), d, 1'($urandom), c);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule